// File: doc/BRIEF.md
# SECDED Read Checker with Error Response

This block sits on the read return path of a memory that stores each 32-bit word together with seven check bits. When a read word comes back from the memory, the block works out the syndrome and the overall parity. It fixes any single flipped bit and spots any word that it cannot repair. It then presents the data phase of the bus read as a bus slave would: read data, a ready signal and an error response.

Each corrected error produces a one-cycle status pulse and no bus error. Each uncorrectable word produces a one-cycle status pulse and the two-cycle bus ERROR response. It also loads the read address into a failing-address register. External error counters use the status pulses together with that register. Protection can be switched off, and read data then passes through untouched. A pipeline-enable input inserts an extra register stage, which adds one cycle of read latency so the block can run at high clock rates.

Top module: `ecc_rd_check`

## Requirements
- R1: Codeword layout: `mem_rdata[31:0]` holds data and `mem_rdata[38:32]` holds check bits. Data bit i sits at Hamming position P(i), the i-th integer, counting upward from 3, that is not a power of two. Check bit 32+k (k=0..5) is the XOR of all data bits whose P has bit k set. Bit 38 makes the XOR of bits 38:0 zero. A clean word is returned unchanged with `hreadyout`=1, `hresp`=0 and no status pulse.
- R2: A word with exactly one flipped data bit is returned corrected. `err_single` pulses for exactly one cycle, `err_double` stays low and `hresp` stays 0.
- R3: A word with exactly one flipped check bit (any of bits 38:32) returns its data bits unchanged and pulses `err_single`, with no bus error.
- R4: A word with two flipped bits pulses `err_double` and returns the raw, uncorrected data bits. The bus answers in two cycles: first `hreadyout`=0 with `hresp`=1, then `hreadyout`=1 with `hresp`=1.
- R5: A word with odd overall parity whose syndrome exceeds 38 (for example, data bits 0, 1 and 26 flipped) is treated as uncorrectable, exactly as in R4.
- R6: `fail_addr` takes the `rd_addr` of an uncorrectable read and shows it from the second response cycle. Clean reads and corrected reads leave it unchanged.
- R7: Reset (`rst_n` low, asynchronous) sets `fail_addr` to 0, `hreadyout` to 1, `hresp` to 0 and both status outputs to 0.
- R8: With `secded_en`=0, `mem_rdata[31:0]` is returned unchanged and no status or error is raised, whatever the check bits hold.
- R9: With `pipe_en`=0, the result of a read sampled at clock edge E is presented in the cycle after E. With `pipe_en`=1, it is presented one cycle later, and the cycle after E shows an idle bus with no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| secded_en | input | 1 | 1 = check and correct, 0 = raw pass-through |
| pipe_en | input | 1 | 1 = insert the extra read pipeline stage |
| rd_valid | input | 1 | Memory read word and address valid this cycle |
| rd_addr | input | ADDR_W | Word address of the read |
| mem_rdata | input | 39 | Data plus check bits from the memory |
| hrdata | output | 32 | Read data of the data phase |
| hreadyout | output | 1 | Low for the first cycle of an error response |
| hresp | output | 1 | High during both cycles of an error response |
| err_single | output | 1 | One-cycle pulse on a corrected error |
| err_double | output | 1 | One-cycle pulse on an uncorrectable error |
| fail_addr | output | ADDR_W | Address of the last uncorrectable read |

## Verification
Clean words with several data patterns show that an error-free codeword raises nothing. Every single-bit flip over all 39 codeword bits then separates data-bit correction from check-bit-only errors. All 741 two-bit flip pairs each give a distinct address, which proves that the error sequence and the address capture never take a double error for a single one. A three-bit flip whose syndrome lands past the last position, reads with protection off, and alternating pipeline settings tell apart the out-of-range decode, the bypass path, and the one-cycle versus two-cycle latency.

// File: rtl/ecc_rd_pkg.sv
package ecc_rd_pkg;
  localparam int DATA_W  = 32;
  localparam int HAM_W   = 6;
  localparam int CHK_W   = HAM_W + 1;
  localparam int CODE_W  = DATA_W + CHK_W;
  localparam int MAX_POS = CODE_W - 1;

  // Hamming position of data bit idx: idx-th non-power-of-two from 3 upward.
  function automatic logic [HAM_W-1:0] data_pos(input int idx);
    int cnt;
    logic [HAM_W-1:0] res;
    cnt = 0;
    res = '0;
    for (int k = 1; k < (1 << HAM_W); k++) begin
      if ((k & (k - 1)) != 0) begin
        if (cnt == idx) res = HAM_W'(k);
        cnt++;
      end
    end
    return res;
  endfunction

  // Check bits for a data word: Hamming part plus overall parity on top.
  function automatic logic [CHK_W-1:0] ecc_gen(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) h = h ^ data_pos(i);
    end
    return {(^d) ^ (^h), h};
  endfunction
endpackage

// File: rtl/ecc_decode.sv
module ecc_decode
  import ecc_rd_pkg::*;
(
  input  logic              secded_en,
  input  logic [CODE_W-1:0] word,
  output logic [DATA_W-1:0] data_out,
  output logic              single_err,
  output logic              double_err,
  output logic [HAM_W-1:0]  syn,
  output logic              par_odd
);
  logic [DATA_W-1:0] raw_d;
  logic [CHK_W-1:0]  raw_c;
  logic [CHK_W-1:0]  regen;
  logic [DATA_W-1:0] flip;
  logic              in_range;
  logic              single_raw;
  logic              double_raw;

  assign raw_d    = word[DATA_W-1:0];
  assign raw_c    = word[CODE_W-1:DATA_W];
  assign regen    = ecc_gen(raw_d);
  assign syn      = regen[HAM_W-1:0] ^ raw_c[HAM_W-1:0];
  assign par_odd  = ^word;
  assign in_range = (syn <= HAM_W'(MAX_POS));

  // One comparator per data bit against its own Hamming position.
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
      assign flip[i] = (syn == data_pos(i));
    end
  endgenerate

  // Odd parity with an in-range syndrome: one bit (zero or power of two = check bit).
  assign single_raw = par_odd & in_range;
  assign double_raw = (~par_odd & (syn != '0)) | (par_odd & ~in_range);

  assign single_err = secded_en & single_raw;
  assign double_err = secded_en & double_raw;
  assign data_out   = (secded_en && single_raw) ? (raw_d ^ flip) : raw_d;
endmodule

// File: rtl/ecc_rd_stage.sv
module ecc_rd_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_pay,
  output logic         out_vld,
  output logic [W-1:0] out_pay
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_pay <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_pay <= in_pay;
    end
  end
endmodule

// File: rtl/ecc_resp_ctrl.sv
module ecc_resp_ctrl #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_sgl,
  input  logic              in_dbl,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              hreadyout,
  output logic              hresp,
  output logic              err_single,
  output logic              err_double,
  output logic [ADDR_W-1:0] fail_addr
);
  logic dbl_now;
  logic sgl_now;
  logic err2_q;

  assign dbl_now = in_vld & in_dbl;
  assign sgl_now = in_vld & in_sgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err2_q    <= 1'b0;
      fail_addr <= '0;
    end else begin
      err2_q <= dbl_now;
      if (dbl_now) fail_addr <= in_addr;
    end
  end

  assign hreadyout  = ~dbl_now;
  assign hresp      = dbl_now | err2_q;
  assign err_single = sgl_now;
  assign err_double = dbl_now;

  p_err_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_double |-> (!hreadyout && hresp));
  p_err_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_double |=> (hreadyout && hresp));
  p_wait_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hreadyout |=> hreadyout);
  p_status_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err_single, err_double}) <= 1);
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_double |=> $stable(fail_addr));
  p_addr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_double |=> (fail_addr == $past(in_addr)));
endmodule

// File: rtl/ecc_rd_check.sv
module ecc_rd_check
  import ecc_rd_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int EXTRA_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              secded_en,
  input  logic              pipe_en,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CODE_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic              hresp,
  output logic              err_single,
  output logic              err_double,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int PAY_W = 2 + DATA_W + ADDR_W;
  localparam int NST   = 1 + EXTRA_STAGES;

  logic [DATA_W-1:0] dec_data;
  logic              dec_sgl;
  logic              dec_dbl;
  logic [HAM_W-1:0]  dec_syn;
  logic              dec_par;

  logic [NST:0]            vld_s;
  logic [NST:0][PAY_W-1:0] pay_s;

  logic              sel_vld;
  logic [PAY_W-1:0]  sel_pay;
  logic              sel_sgl;
  logic              sel_dbl;
  logic [ADDR_W-1:0] sel_addr;

  ecc_decode u_dec (
    .secded_en  (secded_en),
    .word       (mem_rdata),
    .data_out   (dec_data),
    .single_err (dec_sgl),
    .double_err (dec_dbl),
    .syn        (dec_syn),
    .par_odd    (dec_par)
  );

  assign vld_s[0] = rd_valid;
  assign pay_s[0] = {dec_sgl, dec_dbl, dec_data, rd_addr};

  generate
    for (genvar g = 0; g < NST; g++) begin : g_stage
      ecc_rd_stage #(.W(PAY_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (vld_s[g]),
        .in_pay  (pay_s[g]),
        .out_vld (vld_s[g+1]),
        .out_pay (pay_s[g+1])
      );
    end
  endgenerate

  assign sel_vld = pipe_en ? vld_s[NST] : vld_s[1];
  assign sel_pay = pipe_en ? pay_s[NST] : pay_s[1];
  assign {sel_sgl, sel_dbl, hrdata, sel_addr} = sel_pay;

  ecc_resp_ctrl #(.ADDR_W(ADDR_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (sel_vld),
    .in_sgl     (sel_sgl),
    .in_dbl     (sel_dbl),
    .in_addr    (sel_addr),
    .hreadyout  (hreadyout),
    .hresp      (hresp),
    .err_single (err_single),
    .err_double (err_double),
    .fail_addr  (fail_addr)
  );

  p_clean_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && dec_syn == '0 && !dec_par) |->
      (!dec_sgl && !dec_dbl && dec_data == mem_rdata[DATA_W-1:0]));
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !secded_en) |->
      (!dec_sgl && !dec_dbl && dec_data == mem_rdata[DATA_W-1:0]));
  p_odd_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && secded_en && dec_par) |-> $onehot({dec_sgl, dec_dbl}));
  p_lat_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !pipe_en && $stable(pipe_en)) |=> sel_vld);
endmodule

// File: tb/tb_ecc_rd_check.sv
`timescale 1ns/1ps
module tb_ecc_rd_check;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec = 1'b1;
  logic          pipe = 1'b0;
  logic          rv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [38:0]   mem = '0;
  logic [31:0]   hrdata;
  logic          hreadyout, hresp, err_single, err_double;
  logic [AW-1:0] fail_addr;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int tb_pos [32];

  logic [3:0]    c1f, c2f, pre_f;
  logic [31:0]   c1d;
  logic [AW-1:0] c2a;

  always #2 clk = ~clk;

  ecc_rd_check #(.ADDR_W(AW), .EXTRA_STAGES(1)) dut (
    .clk(clk), .rst_n(rst_n), .secded_en(sec), .pipe_en(pipe), .rd_valid(rv),
    .rd_addr(addr), .mem_rdata(mem), .hrdata(hrdata), .hreadyout(hreadyout),
    .hresp(hresp), .err_single(err_single), .err_double(err_double),
    .fail_addr(fail_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Encoder written from the layout in R1, column by column.
  function automatic logic [38:0] enc(input logic [31:0] d);
    logic [6:0] c;
    c = '0;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 32; i++)
        if (((tb_pos[i] >> k) & 1) == 1) c[k] = c[k] ^ d[i];
    c[6] = ^{d, c[5:0]};
    return {c, d};
  endfunction

  task automatic rd(input logic [38:0] w, input logic [AW-1:0] a, input logic pe, input logic en);
    @(negedge clk);
    mem = w; addr = a; pipe = pe; sec = en; rv = 1'b1;
    @(negedge clk);
    rv = 1'b0;
    pre_f = {hreadyout, hresp, err_single, err_double};
    if (pe) @(negedge clk);
    c1f = {hreadyout, hresp, err_single, err_double};
    c1d = hrdata;
    @(negedge clk);
    c2f = {hreadyout, hresp, err_single, err_double};
    c2a = fail_addr;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [38:0] w;
    logic [AW-1:0] keep;
    logic [31:0] pats [6];
    int p;
    p = 3;
    for (int i = 0; i < 32; i++) begin
      while ((p & (p - 1)) == 0) p++;
      tb_pos[i] = p;
      p++;
    end
    pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'h0000_0001; pats[4] = 32'h8000_0000; pats[5] = 32'h1357_9BDF;

    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 flags at reset", {60'b0, hreadyout, hresp, err_single, err_double}, 64'b1000);
    chk("R7 fail_addr at reset", 64'(fail_addr), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: clean words, both latencies
    for (int i = 0; i < 12; i++) begin
      d = pats[i % 6];
      rd(enc(d), AW'(i), i[0], 1'b1);
      chk("R1 data", 64'(c1d), 64'(d));
      chk("R1 flags", 64'(c1f), 64'b1000);
      chk("R1 idle after", 64'(c2f), 64'b1000);
    end

    // R2, R9: each data bit flipped
    for (int i = 0; i < 32; i++) begin
      d = 32'(i) * 32'h9E37_79B9 ^ 32'h0F0F_3C3C;
      w = enc(d) ^ (39'b1 << i);
      rd(w, AW'(100 + i), i[0], 1'b1);
      chk("R2 corrected data", 64'(c1d), 64'(d));
      chk("R2 flags", 64'(c1f), 64'b1010);
      chk("R2 one-cycle pulse", 64'(c2f), 64'b1000);
      if (i[0]) chk("R9 pipelined read quiet one cycle early", 64'(pre_f), 64'b1000);
      else      chk("R9 short read result after one edge", 64'(pre_f), 64'b1010);
    end

    // R3: each check bit flipped
    for (int k = 0; k < 7; k++) begin
      d = pats[k % 6] ^ 32'h00FF_0F00;
      w = enc(d) ^ (39'b1 << (32 + k));
      rd(w, AW'(200 + k), k[0], 1'b1);
      chk("R3 data unchanged", 64'(c1d), 64'(d));
      chk("R3 flags", 64'(c1f), 64'b1010);
    end

    // R4, R6: all two-bit flip pairs
    for (int i = 0; i < 39; i++) begin
      for (int j = i + 1; j < 39; j++) begin
        d = {i[7:0], j[7:0], 16'hC3A5};
        w = enc(d) ^ (39'b1 << i) ^ (39'b1 << j);
        rd(w, AW'(i * 64 + j), (i + j) % 2 == 1, 1'b1);
        chk("R4 raw data", 64'(c1d), 64'(w[31:0]));
        chk("R4 first response cycle", 64'(c1f), 64'b0101);
        chk("R4 second response cycle", 64'(c2f), 64'b1100);
        chk("R6 fail_addr captured", 64'(c2a), 64'(i * 64 + j));
      end
    end

    // R5: positions 3,5,33 xor to 39, odd parity -> uncorrectable
    d = 32'hDEAD_BEEF;
    w = enc(d) ^ 39'b1 ^ (39'b1 << 1) ^ (39'b1 << 26);
    rd(w, 14'h1ABC, 1'b0, 1'b1);
    chk("R5 flags", 64'(c1f), 64'b0101);
    chk("R5 second cycle", 64'(c2f), 64'b1100);
    chk("R5 raw data", 64'(c1d), 64'(w[31:0]));
    keep = c2a;
    chk("R5 fail_addr", 64'(keep), 64'h1ABC);

    // R6: corrected and clean reads leave fail_addr alone
    rd(enc(32'h1111_2222) ^ (39'b1 << 5), 14'h0333, 1'b1, 1'b1);
    chk("R6 hold after single", 64'(c2a), 64'(keep));
    rd(enc(32'h4444_5555), 14'h0777, 1'b0, 1'b1);
    chk("R6 hold after clean", 64'(c2a), 64'(keep));

    // R8: protection off
    for (int i = 0; i < 6; i++) begin
      w = {7'(i * 19 + 1), pats[i] ^ 32'h0000_0100};
      rd(w, AW'(i), i[0], 1'b0);
      chk("R8 raw pass", 64'(c1d), 64'(w[31:0]));
      chk("R8 no status", 64'(c1f), 64'b1000);
      chk("R8 fail_addr untouched", 64'(c2a), 64'(keep));
    end

    // R7: reset after an error clears fail_addr
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 fail_addr cleared", 64'(fail_addr), 64'h0);
    chk("R7 flags after reset", {60'b0, hreadyout, hresp, err_single, err_double}, 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule